// File: doc/BRIEF.md
# Virtual-Channel Packet Data Buffer

This block holds packet payloads for three virtual channels: posted, nonposted and response. Each channel owns a small pool of slots, and each slot holds up to sixteen 32-bit dwords. A command decoder claims a slot by giving a channel and a length. The block picks the lowest free slot of that channel and hands its index back. The decoder then streams the dwords, and they land at consecutive positions in that slot.

Three readers fetch a stored packet by channel and slot. The forwarding reader has a read port of its own. A user reader and a CSR reader share a second port, called the accepted port, and a grant input picks which of them it serves. Each reader walks through the slot one dword per strobe and releases the slot with a done pulse. An error handler can also release a slot without reading it.

Released slots become credits. The block reports them to flow control as three saturating 2-bit fields and keeps a NOP request high while any credit is waiting to be advertised. In retry mode the decoder can drop the packet it is writing, and either the link or the decoder can order a disconnect. A disconnect empties every pool.

Top module: `vc_data_buffer`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, every slot is free, `freed_cnt` is 0, `nop_req` is 0, `overflow` is 0, and both read data outputs are 0.
- R2: A `wr_claim` pulse with `wr_vc` (0 posted, 1 nonposted, 2 response) takes the lowest-indexed free slot of that channel. Its index appears on `slot_addr_out` one cycle later and holds until the next successful claim.
- R3: After a claim with length field L (dwords minus one), `wr_valid` strobes store `wr_data` at positions 0, 1, ... of the claimed slot. Strobes beyond L+1 dwords are ignored and leave the slot unchanged.
- R4: Each `fwd_rd` strobe reads the dword at the forwarding reader's position in slot `fwd_slot` of channel `fwd_vc`. The value appears on `fwd_data` one cycle later and holds until the next read. The position starts at 0, advances by one per strobe and returns to 0 on `fwd_done`.
- R5: With `csr_grant` low, the accepted port serves the user reader and ignores `csr_rd`. With it high, the port serves the CSR reader and ignores `usr_rd`. An ignored strobe does not advance that reader's position, and each reader keeps its own position.
- R6: A done pulse from any reader, or `eh_erase`, releases the addressed slot and adds one credit to its channel. Releasing a slot that is already free has no effect.
- R7: `freed_cnt` packs each channel's pending credits, saturated at 3: nonposted in bits [5:4], posted in [3:2], response in [1:0]. `nop_req` is high exactly when any field is nonzero.
- R8: On `nop_sent`, each channel's pending credit count drops by the value its field showed in that cycle. Credits beyond 3 remain and show up after the pulse.
- R9: A claim on a channel with no free slot sets `overflow` and leaves no packet open, so later `wr_valid` strobes are ignored. `overflow` stays high until reset.
- R10: With `retry_en` high, `wr_drop` while a packet is open releases that slot (one credit) and closes the packet.
- R11: With `retry_en` high, `link_disc` or `dec_disc` frees every slot of every channel, clears all pending credits and closes any open packet.
- R12: With `retry_en` low, `wr_drop`, `link_disc` and `dec_disc` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_claim | input | 1 | Claim a slot for a new packet |
| wr_vc | input | 2 | Channel of the claim |
| wr_len | input | 4 | Packet length in dwords minus one |
| wr_valid | input | 1 | Write strobe for one dword |
| wr_data | input | 32 | Dword to store |
| wr_drop | input | 1 | Discard the open packet (retry mode) |
| retry_en | input | 1 | Retry mode enable |
| link_disc | input | 1 | Disconnect ordered by the link |
| dec_disc | input | 1 | Disconnect ordered by the decoder |
| slot_addr_out | output | SLOT_W | Slot index of the last successful claim |
| fwd_rd | input | 1 | Forwarding read strobe |
| fwd_vc | input | 2 | Forwarding channel |
| fwd_slot | input | SLOT_W | Forwarding slot |
| fwd_done | input | 1 | Forwarding reader releases its slot |
| fwd_data | output | 32 | Forwarding read data |
| usr_rd | input | 1 | User read strobe |
| usr_vc | input | 2 | User channel |
| usr_slot | input | SLOT_W | User slot |
| usr_done | input | 1 | User reader releases its slot |
| csr_rd | input | 1 | CSR read strobe |
| csr_vc | input | 2 | CSR channel |
| csr_slot | input | SLOT_W | CSR slot |
| csr_done | input | 1 | CSR reader releases its slot |
| csr_grant | input | 1 | Accepted port serves the CSR reader |
| acc_data | output | 32 | Accepted port read data |
| eh_erase | input | 1 | Error handler release strobe |
| eh_vc | input | 2 | Error handler channel |
| eh_slot | input | SLOT_W | Error handler slot |
| nop_sent | input | 1 | Flow control sent a NOP |
| freed_cnt | output | 6 | Pending credits per channel, saturated |
| nop_req | output | 1 | Credits are waiting to be advertised |
| overflow | output | 1 | A claim found no free slot |

## Verification
An allocation bitmap that is out of step with the real slot state shows up on the next claim. The index returned on `slot_addr_out` a cycle later is not the lowest free one, or a claim that should overflow does not, or one that should succeed does. A pending-credit count that is wrong appears on `freed_cnt` and `nop_req` in the very cycle after the release or `nop_sent` that corrupted it. A saturation error shows only after a following `nop_sent` exposes the hidden remainder. Cursor errors appear on the next read strobe: the dword returned one cycle later comes from the wrong position. An ignored accepted-port strobe that advances a cursor is caught by the first read after the grant changes.

// File: rtl/vcbuf_pkg.sv
package vcbuf_pkg;

    localparam int NUM_VC  = 3;
    localparam int DATA_W  = 32;
    localparam int POS_W   = 4;
    localparam int MAX_DW  = 1 << POS_W;
    localparam int LEN_W   = POS_W;
    localparam int CNT_W   = POS_W + 1;

    typedef enum logic [1:0] {
        VC_POSTED    = 2'd0,
        VC_NONPOSTED = 2'd1,
        VC_RESPONSE  = 2'd2
    } vc_e;

    // Context of the packet currently being written
    typedef struct packed {
        logic             active;
        logic [1:0]       vc;
        logic [LEN_W-1:0] len;
        logic [CNT_W-1:0] cnt;
    } wr_ctx_t;

    // Flat cell index inside the shared storage array
    function automatic int unsigned cell_index(input int unsigned vc,
                                               input int unsigned slot,
                                               input int unsigned pos,
                                               input int unsigned slots);
        return (vc * slots + slot) * MAX_DW + pos;
    endfunction

endpackage

// File: rtl/vcbuf_slot_pool.sv
module vcbuf_slot_pool #(
    parameter int SLOTS  = 4,
    parameter int SLOT_W = 2,
    parameter int PEND_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              claim,
    input  logic              nop_sent,
    input  logic [SLOTS-1:0]  rel_mask,
    output logic              has_free,
    output logic [SLOT_W-1:0] free_idx,
    output logic [1:0]        credit
);
    localparam int RC_W = $clog2(SLOTS + 1);
    localparam logic [PEND_W:0] PEND_MAX = {1'b0, {PEND_W{1'b1}}};

    logic [SLOTS-1:0]  busy_q;
    logic [PEND_W-1:0] pend_q;
    logic [SLOTS-1:0]  eff_rel;
    logic [SLOTS-1:0]  take;
    logic [RC_W-1:0]   rel_cnt;
    logic [PEND_W:0]   pend_sum;

    // Lowest-indexed free slot
    always_comb begin
        has_free = 1'b0;
        free_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!busy_q[i]) begin
                has_free = 1'b1;
                free_idx = SLOT_W'(i);
            end
        end
    end

    assign credit = (pend_q > PEND_W'(3)) ? 2'd3 : pend_q[1:0];

    always_comb begin
        eff_rel = rel_mask & busy_q;
        rel_cnt = '0;
        for (int i = 0; i < SLOTS; i++) begin
            rel_cnt = rel_cnt + RC_W'(eff_rel[i]);
        end
        take = (claim && has_free) ? (SLOTS'(1) << free_idx) : '0;
        pend_sum = {1'b0, pend_q}
                 - (nop_sent ? (PEND_W+1)'(credit) : '0)
                 + (PEND_W+1)'(rel_cnt);
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            busy_q <= '0;
            pend_q <= '0;
        end else begin
            busy_q <= (busy_q & ~eff_rel) | take;
            pend_q <= (pend_sum > PEND_MAX) ? PEND_MAX[PEND_W-1:0] : pend_sum[PEND_W-1:0];
        end
    end
endmodule

// File: rtl/vcbuf_store.sv
module vcbuf_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 192,
    parameter int AW    = 8,
    parameter int RD_N  = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re    [RD_N],
    input  logic [AW-1:0] raddr [RD_N],
    output logic [DW-1:0] rdata [RD_N]
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < RD_N; p++) begin : g_rd
        always_ff @(posedge clk) begin
            if (rst) begin
                rdata[p] <= '0;
            end else if (re[p]) begin
                rdata[p] <= mem[raddr[p]];
            end
        end
    end
endmodule

// File: rtl/vcbuf_read_cursor.sv
module vcbuf_read_cursor #(
    parameter int POS_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             step,
    input  logic             done,
    output logic [POS_W-1:0] pos
);
    always_ff @(posedge clk) begin
        if (rst || flush || done) begin
            pos <= '0;
        end else if (step) begin
            pos <= pos + POS_W'(1);
        end
    end
endmodule

// File: rtl/vc_data_buffer.sv
module vc_data_buffer
    import vcbuf_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_claim,
    input  logic [1:0]        wr_vc,
    input  logic [3:0]        wr_len,
    input  logic              wr_valid,
    input  logic [31:0]       wr_data,
    input  logic              wr_drop,
    input  logic              retry_en,
    input  logic              link_disc,
    input  logic              dec_disc,
    output logic [SLOT_W-1:0] slot_addr_out,
    input  logic              fwd_rd,
    input  logic [1:0]        fwd_vc,
    input  logic [SLOT_W-1:0] fwd_slot,
    input  logic              fwd_done,
    output logic [31:0]       fwd_data,
    input  logic              usr_rd,
    input  logic [1:0]        usr_vc,
    input  logic [SLOT_W-1:0] usr_slot,
    input  logic              usr_done,
    input  logic              csr_rd,
    input  logic [1:0]        csr_vc,
    input  logic [SLOT_W-1:0] csr_slot,
    input  logic              csr_done,
    input  logic              csr_grant,
    output logic [31:0]       acc_data,
    input  logic              eh_erase,
    input  logic [1:0]        eh_vc,
    input  logic [SLOT_W-1:0] eh_slot,
    input  logic              nop_sent,
    output logic [5:0]        freed_cnt,
    output logic              nop_req,
    output logic              overflow
);
    localparam int MEM_DEPTH = NUM_VC * SLOTS * MAX_DW;
    localparam int MEM_AW    = $clog2(MEM_DEPTH);

    wr_ctx_t           wr_q;
    logic [SLOT_W-1:0] wr_slot_q;
    logic              ovf_q;
    logic [SLOT_W-1:0] addr_q;

    logic              flush;
    logic              drop_fire;
    logic              wr_room;
    logic              wr_fire;
    logic              sel_valid;
    logic              sel_ok;
    logic [SLOT_W-1:0] sel_idx;

    logic              pool_ok    [NUM_VC];
    logic [SLOT_W-1:0] pool_idx   [NUM_VC];
    logic [1:0]        pool_cred  [NUM_VC];
    logic [SLOTS-1:0]  rel_mask   [NUM_VC];
    logic              claim_v    [NUM_VC];

    logic [POS_W-1:0]  fwd_pos, usr_pos, csr_pos;
    logic              usr_step, csr_step;
    logic              rd_en   [2];
    logic [MEM_AW-1:0] rd_addr [2];
    logic [31:0]       rd_data [2];
    logic [MEM_AW-1:0] wr_addr;

    assign flush     = retry_en && (link_disc || dec_disc);
    assign drop_fire = retry_en && wr_drop && wr_q.active;
    assign wr_room   = ({1'b0, wr_q.len} >= wr_q.cnt);
    assign wr_fire   = wr_valid && wr_q.active && wr_room && !wr_claim && !flush && !drop_fire;

    // Channel select for the claim
    always_comb begin
        sel_valid = 1'b0;
        sel_ok    = 1'b0;
        sel_idx   = '0;
        for (int v = 0; v < NUM_VC; v++) begin
            if (wr_vc == 2'(v)) begin
                sel_valid = 1'b1;
                sel_ok    = pool_ok[v];
                sel_idx   = pool_idx[v];
            end
        end
    end

    // One pool per channel, with its release sources
    for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
        always_comb begin
            rel_mask[v] = '0;
            if (fwd_done && fwd_vc == 2'(v)) rel_mask[v][fwd_slot] = 1'b1;
            if (usr_done && usr_vc == 2'(v)) rel_mask[v][usr_slot] = 1'b1;
            if (csr_done && csr_vc == 2'(v)) rel_mask[v][csr_slot] = 1'b1;
            if (eh_erase && eh_vc  == 2'(v)) rel_mask[v][eh_slot]  = 1'b1;
            if (drop_fire && wr_q.vc == 2'(v)) rel_mask[v][wr_slot_q] = 1'b1;
        end

        assign claim_v[v] = wr_claim && !flush && (wr_vc == 2'(v));

        vcbuf_slot_pool #(
            .SLOTS  (SLOTS),
            .SLOT_W (SLOT_W),
            .PEND_W (8)
        ) pool_i (
            .clk      (clk),
            .rst      (rst),
            .flush    (flush),
            .claim    (claim_v[v]),
            .nop_sent (nop_sent),
            .rel_mask (rel_mask[v]),
            .has_free (pool_ok[v]),
            .free_idx (pool_idx[v]),
            .credit   (pool_cred[v])
        );
    end

    // Writer context
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q      <= '0;
            wr_slot_q <= '0;
            ovf_q     <= 1'b0;
            addr_q    <= '0;
        end else if (flush) begin
            wr_q.active <= 1'b0;
        end else if (wr_claim && sel_valid) begin
            if (sel_ok) begin
                wr_q.active <= 1'b1;
                wr_q.vc     <= wr_vc;
                wr_q.len    <= wr_len;
                wr_q.cnt    <= '0;
                wr_slot_q   <= sel_idx;
                addr_q      <= sel_idx;
            end else begin
                wr_q.active <= 1'b0;
                ovf_q       <= 1'b1;
            end
        end else if (drop_fire) begin
            wr_q.active <= 1'b0;
        end else if (wr_fire) begin
            wr_q.cnt <= wr_q.cnt + CNT_W'(1);
        end
    end

    assign wr_addr = MEM_AW'(cell_index(32'(wr_q.vc), 32'(wr_slot_q),
                                        32'(wr_q.cnt[POS_W-1:0]), 32'(SLOTS)));

    // Read cursors: forwarding, user, CSR
    assign usr_step = usr_rd && !csr_grant;
    assign csr_step = csr_rd && csr_grant;

    vcbuf_read_cursor #(.POS_W(POS_W)) fwd_cur_i (
        .clk(clk), .rst(rst), .flush(flush), .step(fwd_rd), .done(fwd_done), .pos(fwd_pos));
    vcbuf_read_cursor #(.POS_W(POS_W)) usr_cur_i (
        .clk(clk), .rst(rst), .flush(flush), .step(usr_step), .done(usr_done), .pos(usr_pos));
    vcbuf_read_cursor #(.POS_W(POS_W)) csr_cur_i (
        .clk(clk), .rst(rst), .flush(flush), .step(csr_step), .done(csr_done), .pos(csr_pos));

    always_comb begin
        rd_en[0]   = fwd_rd;
        rd_addr[0] = MEM_AW'(cell_index(32'(fwd_vc), 32'(fwd_slot), 32'(fwd_pos), 32'(SLOTS)));
        if (csr_grant) begin
            rd_en[1]   = csr_rd;
            rd_addr[1] = MEM_AW'(cell_index(32'(csr_vc), 32'(csr_slot), 32'(csr_pos), 32'(SLOTS)));
        end else begin
            rd_en[1]   = usr_rd;
            rd_addr[1] = MEM_AW'(cell_index(32'(usr_vc), 32'(usr_slot), 32'(usr_pos), 32'(SLOTS)));
        end
    end

    vcbuf_store #(
        .DW    (DATA_W),
        .DEPTH (MEM_DEPTH),
        .AW    (MEM_AW),
        .RD_N  (2)
    ) store_i (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_fire),
        .waddr (wr_addr),
        .wdata (wr_data),
        .re    (rd_en),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    assign fwd_data      = rd_data[0];
    assign acc_data      = rd_data[1];
    assign slot_addr_out = addr_q;
    assign overflow      = ovf_q;
    assign freed_cnt     = {pool_cred[VC_NONPOSTED], pool_cred[VC_POSTED], pool_cred[VC_RESPONSE]};
    assign nop_req       = |freed_cnt;

endmodule

// File: rtl/vc_data_buffer_chk.sv
module vc_data_buffer_chk #(
    parameter int SLOT_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_claim,
    input logic [SLOT_W-1:0] slot_addr_out,
    input logic              overflow,
    input logic              retry_en,
    input logic              link_disc,
    input logic              dec_disc,
    input logic [5:0]        freed_cnt,
    input logic              nop_req,
    input logic              fwd_rd,
    input logic [31:0]       fwd_data,
    input logic              csr_grant,
    input logic              csr_rd,
    input logic              usr_rd,
    input logic [31:0]       acc_data
);
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (freed_cnt == 6'd0 && !overflow && !nop_req)); // R1

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_claim |=> $stable(slot_addr_out)); // R2

    AST_FWD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !fwd_rd |=> $stable(fwd_data)); // R4

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(csr_grant ? csr_rd : usr_rd) |=> $stable(acc_data)); // R5

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow); // R9

    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (rst)
        !wr_claim |=> !$rose(overflow)); // R9

    AST_DISC_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (retry_en && (link_disc || dec_disc)) |=> (freed_cnt == 6'd0)); // R11
endmodule

bind vc_data_buffer vc_data_buffer_chk #(.SLOT_W(SLOT_W)) chk_i (.*);

// File: tb/vc_data_buffer_tb_top.sv
`timescale 1ns/1ps
module vc_data_buffer_tb_top;
    localparam int SLOTS  = 4;
    localparam int SLOT_W = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic              wr_claim = 0, wr_valid = 0, wr_drop = 0, retry_en = 0;
    logic              link_disc = 0, dec_disc = 0;
    logic [1:0]        wr_vc = 0;
    logic [3:0]        wr_len = 0;
    logic [31:0]       wr_data = 0;
    logic              fwd_rd = 0, fwd_done = 0, usr_rd = 0, usr_done = 0;
    logic              csr_rd = 0, csr_done = 0, csr_grant = 0, eh_erase = 0, nop_sent = 0;
    logic [1:0]        fwd_vc = 0, usr_vc = 0, csr_vc = 0, eh_vc = 0;
    logic [SLOT_W-1:0] fwd_slot = 0, usr_slot = 0, csr_slot = 0, eh_slot = 0;
    logic [SLOT_W-1:0] slot_addr_out;
    logic [31:0]       fwd_data, acc_data;
    logic [5:0]        freed_cnt;
    logic              nop_req, overflow;

    vc_data_buffer #(.SLOTS(SLOTS)) dut_i (.*);

    int    n_tests = 0;
    int    n_fail  = 0;
    string phase   = "R1";
    bit    finished = 0;

    // ---------------- reference model ----------------
    bit  m_busy  [3][SLOTS];
    int  m_pend  [3];
    int  m_mem   [3][SLOTS][16];
    bit  m_known [3][SLOTS][16];
    bit  m_wact;
    int  m_wvc, m_wslot, m_wlen, m_wcnt;
    bit  m_ovf;
    int  m_addr;
    int  m_fpos, m_upos, m_cpos;
    int  m_fdata, m_adata;
    bit  m_fknown, m_aknown;

    function automatic int sat3(int v);
        return (v > 3) ? 3 : v;
    endfunction

    task automatic model_release(int vc, int slot, ref bit rel [3][SLOTS]);
        if (vc < 3) rel[vc][slot] = 1;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int v = 0; v < 3; v++) begin
                m_pend[v] = 0;
                for (int s = 0; s < SLOTS; s++) m_busy[v][s] = 0;
            end
            m_wact = 0; m_wvc = 0; m_wslot = 0; m_wlen = 0; m_wcnt = 0;
            m_ovf = 0; m_addr = 0; m_fpos = 0; m_upos = 0; m_cpos = 0;
            m_fdata = 0; m_adata = 0; m_fknown = 1; m_aknown = 1;
        end else begin
            bit flush, drop_fire, wfire;
            bit rel [3][SLOTS];
            int fidx;
            int ucnt;
            flush     = retry_en && (link_disc || dec_disc);
            drop_fire = retry_en && wr_drop && m_wact;
            wfire     = wr_valid && m_wact && (m_wcnt <= m_wlen) && !wr_claim && !flush && !drop_fire;
            // reads use the stored contents before this cycle's write
            if (fwd_rd) begin
                m_fdata  = m_mem[fwd_vc][fwd_slot][m_fpos];
                m_fknown = m_known[fwd_vc][fwd_slot][m_fpos];
            end
            if (csr_grant ? csr_rd : usr_rd) begin
                if (csr_grant) begin
                    m_adata  = m_mem[csr_vc][csr_slot][m_cpos];
                    m_aknown = m_known[csr_vc][csr_slot][m_cpos];
                end else begin
                    m_adata  = m_mem[usr_vc][usr_slot][m_upos];
                    m_aknown = m_known[usr_vc][usr_slot][m_upos];
                end
            end
            if (flush || fwd_done) m_fpos = 0; else if (fwd_rd) m_fpos = (m_fpos + 1) % 16;
            if (flush || usr_done) m_upos = 0; else if (usr_rd && !csr_grant) m_upos = (m_upos + 1) % 16;
            if (flush || csr_done) m_cpos = 0; else if (csr_rd && csr_grant) m_cpos = (m_cpos + 1) % 16;
            if (wfire) begin
                m_mem[m_wvc][m_wslot][m_wcnt]   = int'(wr_data);
                m_known[m_wvc][m_wslot][m_wcnt] = 1;
            end
            // slot pools
            for (int v = 0; v < 3; v++) for (int s = 0; s < SLOTS; s++) rel[v][s] = 0;
            if (fwd_done) model_release(fwd_vc, fwd_slot, rel);
            if (usr_done) model_release(usr_vc, usr_slot, rel);
            if (csr_done) model_release(csr_vc, csr_slot, rel);
            if (eh_erase) model_release(eh_vc, eh_slot, rel);
            if (drop_fire) model_release(m_wvc, m_wslot, rel);
            fidx = -1;
            if (wr_vc < 3) begin
                for (int s = SLOTS - 1; s >= 0; s--) if (!m_busy[wr_vc][s]) fidx = s;
            end
            if (flush) begin
                for (int v = 0; v < 3; v++) begin
                    m_pend[v] = 0;
                    for (int s = 0; s < SLOTS; s++) m_busy[v][s] = 0;
                end
                m_wact = 0;
            end else begin
                for (int v = 0; v < 3; v++) begin
                    ucnt = 0;
                    for (int s = 0; s < SLOTS; s++) begin
                        if (rel[v][s] && m_busy[v][s]) begin
                            ucnt++;
                            m_busy[v][s] = 0;
                        end
                    end
                    m_pend[v] = m_pend[v] - (nop_sent ? sat3(m_pend[v]) : 0) + ucnt;
                    if (m_pend[v] > 255) m_pend[v] = 255;
                end
                if (wr_claim && wr_vc < 3) begin
                    if (fidx >= 0) begin
                        m_busy[wr_vc][fidx] = 1;
                        m_wact = 1; m_wvc = wr_vc; m_wslot = fidx;
                        m_wlen = wr_len; m_wcnt = 0; m_addr = fidx;
                    end else begin
                        m_wact = 0; m_ovf = 1;
                    end
                end else if (drop_fire) begin
                    m_wact = 0;
                end else if (wfire) begin
                    m_wcnt++;
                end
            end
        end
    end

    // ---------------- comparison ----------------
    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s (phase %s) at %0t: got %h expected %h", req, phase, $time, got, exp);
        end
    endtask

    always @(posedge clk) begin
        #5;
        if (!finished) begin
            logic [5:0] ef;
            ef = {2'(sat3(m_pend[1])), 2'(sat3(m_pend[0])), 2'(sat3(m_pend[2]))};
            chk(rst ? "R1" : "R2", 32'(slot_addr_out), 32'(m_addr));
            chk(rst ? "R1" : "R7", 32'(freed_cnt), 32'(ef));
            chk(rst ? "R1" : "R7", 32'(nop_req), 32'(ef != 0));
            chk(rst ? "R1" : "R9", 32'(overflow), 32'(m_ovf));
            if (m_fknown) chk(rst ? "R1" : "R4", fwd_data, m_fdata);
            if (m_aknown) chk(rst ? "R1" : "R5", acc_data, m_adata);
        end
    end

    // ---------------- stimulus ----------------
    task automatic step();
        @(negedge clk);
        wr_claim = 0; wr_valid = 0; wr_drop = 0; link_disc = 0; dec_disc = 0;
        fwd_rd = 0; fwd_done = 0; usr_rd = 0; usr_done = 0;
        csr_rd = 0; csr_done = 0; eh_erase = 0; nop_sent = 0;
    endtask

    task automatic claim(int vc, int len);
        wr_claim = 1; wr_vc = 2'(vc); wr_len = 4'(len); step();
    endtask

    task automatic put(logic [31:0] d);
        wr_valid = 1; wr_data = d; step();
    endtask

    task automatic erase(int vc, int slot);
        eh_erase = 1; eh_vc = 2'(vc); eh_slot = SLOT_W'(slot); step();
    endtask

    task automatic nop();
        nop_sent = 1; step();
    endtask

    initial begin
        phase = "R1";
        repeat (3) step();
        chk("R1", 32'(freed_cnt), 32'd0);
        chk("R1", 32'(overflow), 32'd0);
        rst = 0;
        step();

        // R3: prefill nonposted slot 0, release, then short packet with an extra strobe
        phase = "R3";
        claim(1, 3);
        for (int i = 0; i < 4; i++) put(32'hA000_0000 + i);
        erase(1, 0);
        claim(1, 1);
        put(32'hB000_0001); put(32'hB000_0002); put(32'hB000_0003);
        claim(0, 3);
        for (int i = 0; i < 4; i++) put(32'hC000_0000 + i);
        claim(2, 0);
        put(32'hD000_0000);
        usr_vc = 1; usr_slot = 0;
        for (int i = 0; i < 3; i++) begin usr_rd = 1; step(); end
        chk("R3", acc_data, 32'hA000_0002);

        // R4: forwarding reads posted slot 0, releases it
        phase = "R4";
        fwd_vc = 0; fwd_slot = 0;
        for (int i = 0; i < 4; i++) begin fwd_rd = 1; fwd_done = (i == 3); step(); end
        chk("R4", fwd_data, 32'hC000_0003);

        // R5: CSR strobes ignored without grant, then served under grant
        phase = "R5";
        usr_done = 1; step();
        usr_rd = 1; csr_rd = 1; csr_vc = 2; csr_slot = 0; step();
        csr_grant = 1;
        csr_rd = 1; usr_rd = 1; csr_done = 1; step();
        chk("R5", acc_data, 32'hD000_0000);
        csr_grant = 0;
        usr_done = 1; usr_vc = 1; step();

        // R6: releasing a free slot adds nothing
        phase = "R6";
        erase(0, 0);
        erase(2, 3);
        nop(); nop();
        chk("R6", 32'(freed_cnt), 32'd0);

        // R9: fill posted, one more claim overflows
        phase = "R9";
        for (int s = 0; s < SLOTS; s++) begin claim(0, 0); put(32'hE000_0000 + s); end
        claim(0, 0);
        put(32'hFFFF_FFFF);
        chk("R9", 32'(overflow), 32'd1);

        // R8: four credits on one channel, saturation then remainder
        phase = "R8";
        for (int s = 0; s < SLOTS; s++) erase(0, s);
        chk("R8", 32'(freed_cnt), 32'h0C);
        nop();
        chk("R8", 32'(freed_cnt), 32'h04);
        nop();

        // R12: drop and disconnect without retry mode
        phase = "R12";
        retry_en = 0;
        claim(0, 0); put(32'h1200_0000);
        wr_drop = 1; step();
        link_disc = 1; step();
        dec_disc = 1; step();
        claim(0, 0);
        chk("R12", 32'(slot_addr_out), 32'd1);

        // R10: drop in retry mode frees the open slot
        phase = "R10";
        retry_en = 1;
        wr_drop = 1; step();
        chk("R10", 32'(freed_cnt), 32'h04);
        claim(0, 2);
        chk("R10", 32'(slot_addr_out), 32'd1);
        put(32'h1000_0000);

        // R11: disconnect empties everything
        phase = "R11";
        claim(1, 0); erase(0, 0);
        link_disc = 1; step();
        chk("R11", 32'(freed_cnt), 32'd0);
        claim(0, 0);
        chk("R11", 32'(slot_addr_out), 32'd0);
        claim(1, 0); erase(1, 0);
        dec_disc = 1; step();
        chk("R11", 32'(freed_cnt), 32'd0);
        retry_en = 0;
        repeat (3) step();

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule